// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This unit does arithmetic on two 32-bit words treated as packed lanes: either two 16-bit halfwords or four 8-bit bytes. One 3-bit operation code picks the lane shape and the operation. The operations are lane-wise add, lane-wise subtract, and two cross forms that pair each halfword of the first operand with the opposite halfword of the second. A 2-bit flavour code picks how each lane's raw sum or difference becomes the lane result:

- **Wrapping (modular):** the result wraps, and per-lane greater-or-equal flags are produced.
- **Unsigned saturating:** the result clamps at the lane limits.
- **Unsigned halving:** the full-precision value is shifted right by one.

A caller presents the operands, the operation code and the flavour together with a one-cycle strobe. The result register and the 4-bit flag register update on the next rising clock edge. Reserved codes are refused: the registers keep their values, and a one-cycle illegal indication is raised instead. A synchronous active-high reset clears every output to zero.

Top module: `simd_lane_addsub`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o`, `ge_o` and `illegal_o` become zero.
- R2: Operation codes are as follows. 0 adds the two halfword pairs, 3 subtracts them (A minus B), 4 adds the four byte pairs, and 7 subtracts them. A strobed operation shows on `result_o` after the first rising edge that samples `valid_i` high. Byte lane i occupies bits 8i+7:8i, and halfword lane 0 occupies bits 15:0.
- R3: Code 1 (cross add-subtract) gives a low halfword of A[15:0] minus B[31:16] and a high halfword of A[31:16] plus B[15:0]. Code 2 (cross subtract-add) gives a low halfword of A[15:0] plus B[31:16] and a high halfword of A[31:16] minus B[15:0].
- R4: With flavour 0 (wrapping), each lane result is the sum or difference modulo the lane width. A lane's flag is 1 on carry-out for an add and 1 on no-borrow for a subtract. A halfword operation writes its low-lane flag to `ge_o[1:0]` and its high-lane flag to `ge_o[3:2]`. A byte operation writes byte lane i's flag to `ge_o[i]`.
- R5: With flavour 1 (unsigned saturating), a lane add that overflows gives all ones, and a lane subtract that underflows gives zero. Otherwise the lane result is the exact value.
- R6: With flavour 2 (unsigned halving), each lane result is bits W:1 of the (W+1)-bit sum or two's-complement difference, where W is the lane width.
- R7: Flavours 1 and 2 leave `ge_o` unchanged.
- R8: Operation codes 5 and 6 and flavour code 3 are reserved. A strobe with a reserved code leaves `result_o` and `ge_o` unchanged, and `illegal_o` is high for exactly the one following cycle.
- R9: A cycle without a strobe leaves `result_o` and `ge_o` unchanged and drives `illegal_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe: operate on the inputs this cycle |
| op_i | input | 3 | Operation code (0,1,2,3,4,7 used; 5,6 reserved) |
| flav_i | input | 2 | Flavour: 0 wrapping, 1 saturating, 2 halving, 3 reserved |
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| result_o | output | 32 | Registered packed result |
| ge_o | output | 4 | Registered per-lane greater-or-equal flags |
| illegal_o | output | 1 | One-cycle pulse after a strobe with a reserved code |

## Verification
In one cycle the unit can both clamp a lane and hold its flag register. A saturating or halving strobe computes new lane results while it must leave `ge_o` exactly as the last wrapping operation set it. The bench first runs wrapping vectors that leave a distinctive flag pattern. It then runs saturating and halving vectors that overflow and underflow lanes, and judges each one on the new result together with the unchanged flags. Reserved-code strobes are placed between valid ones, and are judged on the pulse, the held registers and the pulse ending.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

    typedef enum logic [2:0] {
        OP_ADD16  = 3'd0,
        OP_XADDSB = 3'd1,
        OP_XSUBAD = 3'd2,
        OP_SUB16  = 3'd3,
        OP_ADD8   = 3'd4,
        OP_RSV5   = 3'd5,
        OP_RSV6   = 3'd6,
        OP_SUB8   = 3'd7
    } lane_op_e;

    typedef enum logic [1:0] {
        FL_WRAP = 2'd0,
        FL_SAT  = 2'd1,
        FL_HALF = 2'd2,
        FL_RSV  = 2'd3
    } lane_flav_e;

    typedef struct packed {
        logic legal;
        logic byte_mode;
        logic swap;
        logic sub_lo;
        logic sub_hi;
        logic ge_write;
    } lane_ctrl_t;

    function automatic logic flav_writes_flags(input lane_flav_e f);
        return (f == FL_WRAP);
    endfunction

    function automatic logic op_is_reserved(input lane_op_e o);
        return (o == OP_RSV5) || (o == OP_RSV6);
    endfunction

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
    import simd_lane_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic [1:0] flav_i,
    output lane_ctrl_t ctrl_o
);
    lane_op_e   op;
    lane_flav_e fl;

    assign op = lane_op_e'(op_i);
    assign fl = lane_flav_e'(flav_i);

    always_comb begin
        ctrl_o = '0;
        ctrl_o.legal = !op_is_reserved(op) && (fl != FL_RSV);
        unique case (op)
            OP_ADD16:  begin ctrl_o.sub_lo = 1'b0; ctrl_o.sub_hi = 1'b0; end
            OP_XADDSB: begin ctrl_o.swap = 1'b1; ctrl_o.sub_lo = 1'b1; ctrl_o.sub_hi = 1'b0; end
            OP_XSUBAD: begin ctrl_o.swap = 1'b1; ctrl_o.sub_lo = 1'b0; ctrl_o.sub_hi = 1'b1; end
            OP_SUB16:  begin ctrl_o.sub_lo = 1'b1; ctrl_o.sub_hi = 1'b1; end
            OP_ADD8:   begin ctrl_o.byte_mode = 1'b1; end
            OP_SUB8:   begin ctrl_o.byte_mode = 1'b1; ctrl_o.sub_lo = 1'b1; ctrl_o.sub_hi = 1'b1; end
            default:   begin ctrl_o.byte_mode = 1'b0; end
        endcase
        ctrl_o.ge_write = ctrl_o.legal && flav_writes_flags(fl);
    end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
    import simd_lane_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         sub_i,
    input  logic [1:0]   flav_i,
    output logic [W-1:0] res_o,
    output logic         ge_o
);
    logic [W:0] full;
    logic       top;

    always_comb begin
        if (sub_i)
            full = {1'b0, x_i} - {1'b0, y_i};
        else
            full = {1'b0, x_i} + {1'b0, y_i};
        top  = full[W];
        ge_o = sub_i ? !top : top;
        unique case (lane_flav_e'(flav_i))
            FL_SAT: begin
                if (top)
                    res_o = sub_i ? '0 : '1;
                else
                    res_o = full[W-1:0];
            end
            FL_HALF: res_o = full[W:1];
            default: res_o = full[W-1:0];
        endcase
    end
endmodule

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub
    import simd_lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        flav_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        ge_o,
    output logic              illegal_o
);
    localparam int N_HALF = 2;
    localparam int N_BYTE = 4;
    localparam int HALF_W = DATA_W / N_HALF;
    localparam int BYTE_W = DATA_W / N_BYTE;

    lane_ctrl_t ctrl;

    simd_op_decode i_dec (
        .op_i   (op_i),
        .flav_i (flav_i),
        .ctrl_o (ctrl)
    );

    // Halfword path with optional cross pairing of B
    logic [N_HALF-1:0][HALF_W-1:0] a_h, b_h, y_h, r_h;
    logic [N_HALF-1:0]             sub_h, ge_h;

    assign a_h = a_i;
    assign b_h = b_i;
    assign y_h[0] = ctrl.swap ? b_h[1] : b_h[0];
    assign y_h[1] = ctrl.swap ? b_h[0] : b_h[1];
    assign sub_h  = {ctrl.sub_hi, ctrl.sub_lo};

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        simd_lane #(.W(HALF_W)) i_lane (
            .x_i    (a_h[h]),
            .y_i    (y_h[h]),
            .sub_i  (sub_h[h]),
            .flav_i (flav_i),
            .res_o  (r_h[h]),
            .ge_o   (ge_h[h])
        );
    end

    // Byte path
    logic [N_BYTE-1:0][BYTE_W-1:0] a_b, b_b, r_b;
    logic [N_BYTE-1:0]             ge_b;

    assign a_b = a_i;
    assign b_b = b_i;

    for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
        simd_lane #(.W(BYTE_W)) i_lane (
            .x_i    (a_b[k]),
            .y_i    (b_b[k]),
            .sub_i  (ctrl.sub_lo),
            .flav_i (flav_i),
            .res_o  (r_b[k]),
            .ge_o   (ge_b[k])
        );
    end

    logic [DATA_W-1:0] res_next;
    logic [3:0]        ge_next;

    always_comb begin
        if (ctrl.byte_mode) begin
            res_next = r_b;
            ge_next  = ge_b;
        end else begin
            res_next = r_h;
            ge_next  = {ge_h[1], ge_h[1], ge_h[0], ge_h[0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            ge_o      <= '0;
            illegal_o <= 1'b0;
        end else begin
            illegal_o <= valid_i && !ctrl.legal;
            if (valid_i && ctrl.legal) begin
                result_o <= res_next;
                if (ctrl.ge_write)
                    ge_o <= ge_next;
            end
        end
    end
endmodule

// File: rtl/simd_lane_addsub_chk.sv
module simd_lane_addsub_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [2:0]  op_i,
    input logic [1:0]  flav_i,
    input logic [31:0] a_i,
    input logic [31:0] result_o,
    input logic [3:0]  ge_o,
    input logic        illegal_o
);
    // R9: no strobe, registers hold and no pulse
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(result_o) && $stable(ge_o) && !illegal_o));

    // R8: reserved code gives pulse and holds state
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (op_i == 3'd5 || op_i == 3'd6 || flav_i == 2'd3)) |=>
            (illegal_o && $stable(result_o) && $stable(ge_o)));

    // R8: legal strobe gives no pulse
    a_r8_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i != 3'd5 && op_i != 3'd6 && flav_i != 2'd3) |=> !illegal_o);

    // R7: non-wrapping flavours keep flags
    a_r7_flags_kept: assert property (@(posedge clk) disable iff (rst)
        (valid_i && flav_i != 2'd0) |=> $stable(ge_o));

    // R4: halfword wrapping ops write flag pairs
    a_r4_flag_pairs: assert property (@(posedge clk) disable iff (rst)
        (valid_i && flav_i == 2'd0 && op_i <= 3'd3) |=>
            (ge_o[1] == ge_o[0] && ge_o[3] == ge_o[2]));

    // R5: saturating halfword add never goes below A
    a_r5_sat_add: assert property (@(posedge clk) disable iff (rst)
        (valid_i && flav_i == 2'd1 && op_i == 3'd0) |=>
            (result_o[15:0] >= $past(a_i[15:0]) && result_o[31:16] >= $past(a_i[31:16])));

    // R5: saturating halfword subtract never exceeds A
    a_r5_sat_sub: assert property (@(posedge clk) disable iff (rst)
        (valid_i && flav_i == 2'd1 && op_i == 3'd3) |=>
            (result_o[15:0] <= $past(a_i[15:0]) && result_o[31:16] <= $past(a_i[31:16])));

    // R1: reset clears the outputs
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (result_o == '0 && ge_o == '0 && !illegal_o));
endmodule

bind simd_lane_addsub simd_lane_addsub_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .flav_i    (flav_i),
    .a_i       (a_i),
    .result_o  (result_o),
    .ge_o      (ge_o),
    .illegal_o (illegal_o)
);

// File: tb/test_simd_lane_addsub.sv
module test_simd_lane_addsub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  flav_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] result_o;
    logic [3:0]  ge_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    simd_lane_addsub i_simd_lane_addsub (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .flav_i(flav_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o), .ge_o(ge_o), .illegal_o(illegal_o)
    );

    // {op, flavour, a, b, expected result, expected flags after the step}
    localparam int NV = 16;
    localparam logic [104:0] VEC [NV] = '{
        {3'd0, 2'd0, 32'h8000_0001, 32'h8000_FFFF, 32'h0000_0000, 4'b1111},
        {3'd3, 2'd0, 32'h0005_0010, 32'h0006_0010, 32'hFFFF_0000, 4'b0011},
        {3'd1, 2'd0, 32'h1000_0300, 32'h0200_0100, 32'h1100_0100, 4'b0011},
        {3'd2, 2'd0, 32'h0003_1000, 32'h2000_0002, 32'h0001_3000, 4'b1100},
        {3'd4, 2'd0, 32'hFF10_8001, 32'h0120_8001, 32'h0030_0002, 4'b1010},
        {3'd7, 2'd0, 32'h0510_0203, 32'h0610_0302, 32'hFF00_FF01, 4'b0101},
        {3'd0, 2'd1, 32'hFFF0_1000, 32'h0020_2000, 32'hFFFF_3000, 4'b0101},
        {3'd3, 2'd1, 32'h0010_0050, 32'h0020_0040, 32'h0000_0010, 4'b0101},
        {3'd7, 2'd1, 32'h80FF_0010, 32'h7F00_0120, 32'h01FF_0000, 4'b0101},
        {3'd4, 2'd1, 32'hF001_807F, 32'h2001_8001, 32'hFF02_FF80, 4'b0101},
        {3'd1, 2'd1, 32'h0100_0100, 32'h0200_FFFF, 32'hFFFF_0000, 4'b0101},
        {3'd0, 2'd2, 32'hFFFF_0003, 32'h0001_0004, 32'h8000_0003, 4'b0101},
        {3'd3, 2'd2, 32'h0000_0010, 32'h0002_0004, 32'hFFFF_0006, 4'b0101},
        {3'd7, 2'd2, 32'h0010_0502, 32'h0100_0304, 32'hFF08_01FF, 4'b0101},
        {3'd2, 2'd2, 32'h0004_0006, 32'h0008_0002, 32'h0001_0007, 4'b0101},
        {3'd4, 2'd2, 32'hFF01_0203, 32'hFF01_0001, 32'hFF01_0102, 4'b0101}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [2:0] op, input logic [1:0] fl,
                          input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_i = op; flav_i = fl; a_i = a; b_i = b; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 result", result_o, 32'h0);
        check("R1 flags", {28'h0, ge_o}, 32'h0);
        check("R1 illegal", {31'h0, illegal_o}, 32'h0);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [104:0] v;
            string tag;
            v = VEC[i];
            strobe(v[104:102], v[101:100], v[99:68], v[67:36]);
            case (v[101:100])
                2'd0:    tag = (v[104:102] inside {3'd1, 3'd2}) ? "R3 R4" : "R2 R4";
                2'd1:    tag = "R5 R7";
                default: tag = "R6 R7";
            endcase
            check({tag, " result"}, result_o, v[35:4]);
            check({tag, " flags"}, {28'h0, ge_o}, {28'h0, v[3:0]});
            check("R8 no pulse on legal op", {31'h0, illegal_o}, 32'h0);
        end

        // R9: inputs change without a strobe
        @(negedge clk);
        op_i = 3'd0; flav_i = 2'd0; a_i = 32'hFFFF_FFFF; b_i = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R9 result held", result_o, 32'hFF01_0102);
        check("R9 flags held", {28'h0, ge_o}, 32'h5);
        check("R9 no pulse", {31'h0, illegal_o}, 32'h0);

        // R8: reserved operation codes and flavour
        strobe(3'd5, 2'd0, 32'h1111_1111, 32'h2222_2222);
        check("R8 op5 pulse", {31'h0, illegal_o}, 32'h1);
        check("R8 op5 result held", result_o, 32'hFF01_0102);
        check("R8 op5 flags held", {28'h0, ge_o}, 32'h5);
        @(negedge clk);
        check("R8 pulse ends", {31'h0, illegal_o}, 32'h0);
        strobe(3'd6, 2'd1, 32'h1111_1111, 32'h2222_2222);
        check("R8 op6 pulse", {31'h0, illegal_o}, 32'h1);
        check("R8 op6 result held", result_o, 32'hFF01_0102);
        strobe(3'd0, 2'd3, 32'h0000_FFFF, 32'h0000_0001);
        check("R8 flavour3 pulse", {31'h0, illegal_o}, 32'h1);
        check("R8 flavour3 flags held", {28'h0, ge_o}, 32'h5);
        check("R8 flavour3 result held", result_o, 32'hFF01_0102);

        // R4: byte subtract with equal lanes sets all flags
        strobe(3'd7, 2'd0, 32'h7F7F_7F7F, 32'h7F7F_7F7F);
        check("R4 equal-lane subtract", result_o, 32'h0);
        check("R4 equal-lane flags", {28'h0, ge_o}, 32'hF);

        // R1: synchronous reset mid-run
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check("R1 reset result", result_o, 32'h0);
        check("R1 reset flags", {28'h0, ge_o}, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule